// File: doc/BRIEF.md
# Coprocessor Status Flag Register

This block holds the sixteen-bit status word of a small graphics coprocessor core. The word carries four ALU condition flags (zero, carry, sign, overflow), a running flag, a flag for a pending ROM byte fetch, five per-instruction prefix flags (two mode-prefix bits, two immediate-byte bits and a register-prefix bit) and an interrupt flag. The execution datapath writes the condition flags through separate strobes. The decoder reports instruction starts, prefix state and the stop instruction. The host bus logic supplies a read strobe for the word and a configuration bit that masks interrupts.

A stop instruction clears the running flag and the register-prefix and mode-prefix bits. It also raises the interrupt flag unless the mask bit is set. A host read of the word clears the interrupt flag. The interrupt request pin comes straight from the stored interrupt bit, so it changes on the clock edge that follows the event that sets or clears it. The word reads combinationally from the registers, so a host read sees the interrupt bit before the read clears it.

Top module: `cop_flag_reg`

## Requirements
- R1: While `rst_n` is low, every bit of `status` is 0 and `irq` is 0, including the running flag.
- R2: Bits 0, 7, 13 and 14 of `status` always read 0, whatever the inputs do.
- R3: At the clock edge after `zs_we` is high, bit 1 (zero) becomes 1 exactly when `alu_res[15:0]` is all zeros, and bit 3 (sign) takes the value of `alu_res[15]`.
- R4: At the clock edge after `cy_we` is high, bit 2 (carry) takes `cy_in`. At the clock edge after `ov_we` is high, bit 4 (overflow) takes `ov_in`.
- R5: Bit 5 (running) is set by `go_set` and cleared by `stop`. When both are high in the same cycle, `stop` wins.
- R6: When `mode_we` is high, bits 8..12 load `mode_in[4:0]`. The order is bit 8 alt1 = mode_in[0], bit 9 alt2 = mode_in[1], bit 10 immediate-low = mode_in[2], bit 11 immediate-high = mode_in[3], bit 12 register-prefix = mode_in[4]. A `stop` forces bits 8, 9 and 12 to 0 and takes precedence over `mode_we` for those bits.
- R7: A `stop` while `irq_mask` is 0 sets bit 15 (interrupt). A `stop` while `irq_mask` is 1 does not set it.
- R8: A `host_rd` clears bit 15 at the next edge, except when a `stop` with `irq_mask` 0 arrives in the same cycle, in which case bit 15 is set.
- R9: `irq` equals bit 15 of `status` and rises only in the cycle after an unmasked `stop`.
- R10: Bit 6 (ROM fetch pending) is set by `rom_set` and cleared by `rom_clr`. When both are high in the same cycle, `rom_set` wins.
- R11: A flag whose update strobes are all low keeps its value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_res | input | RES_W | Result from the ALU, used for the zero and sign flags |
| zs_we | input | 1 | Update zero and sign from `alu_res` |
| cy_we | input | 1 | Update carry |
| cy_in | input | 1 | New carry value |
| ov_we | input | 1 | Update overflow |
| ov_in | input | 1 | New overflow value |
| go_set | input | 1 | Start execution (sets running flag) |
| stop | input | 1 | Stop instruction executed |
| rom_set | input | 1 | ROM byte fetch started |
| rom_clr | input | 1 | ROM byte fetch finished |
| mode_we | input | 1 | Load prefix bits from `mode_in` |
| mode_in | input | 5 | Prefix bits {reg-prefix, imm-high, imm-low, alt2, alt1} |
| host_rd | input | 1 | Host read of the status word |
| irq_mask | input | 1 | 1 masks interrupt generation on stop |
| status | output | 16 | Status word |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that every strobe is a clean single-cycle level sampled at the rising edge, and that any combination of strobes may occur in one cycle, including `stop` with `go_set`, `mode_we` or `host_rd`. The random stimulus draws each strobe independently every cycle, so these collisions arise often. `stop` and `irq_mask` are drawn with skewed probabilities so that masked stops, unmasked stops and reads of a pending interrupt all occur. Directed steps add a stop that coincides with a host read, a masked stop on a pending interrupt, an all-zero ALU result and a reset in the middle of traffic.

// File: rtl/cop_flag_pkg.sv
package cop_flag_pkg;
   localparam int STAT_W  = 16;
   localparam int ZCHK_W  = 16;
   localparam int MODE_W  = 5;

   localparam int B_ZERO  = 1;
   localparam int B_CARRY = 2;
   localparam int B_SIGN  = 3;
   localparam int B_OVF   = 4;
   localparam int B_RUN   = 5;
   localparam int B_ROMP  = 6;
   localparam int B_ALT1  = 8;
   localparam int B_ALT2  = 9;
   localparam int B_IMML  = 10;
   localparam int B_IMMH  = 11;
   localparam int B_RPFX  = 12;
   localparam int B_IRQ   = 15;

   typedef struct packed {
      logic rpfx;
      logic immh;
      logic imml;
      logic alt2;
      logic alt1;
   } mode_t;
endpackage

// File: rtl/cop_cond_flags.sv
module cop_cond_flags
   import cop_flag_pkg::*;
#(
   parameter int RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RES_W-1:0] alu_res,
   input  logic             zs_we,
   input  logic             cy_we,
   input  logic             cy_in,
   input  logic             ov_we,
   input  logic             ov_in,
   output logic             zero_q,
   output logic             carry_q,
   output logic             sign_q,
   output logic             ovf_q
);
   localparam int SIGN_POS = ZCHK_W - 1;

   logic res_is_zero;
   assign res_is_zero = (alu_res[ZCHK_W-1:0] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zero_q  <= 1'b0;
         sign_q  <= 1'b0;
         carry_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (zs_we) begin
            zero_q <= res_is_zero;
            sign_q <= alu_res[SIGN_POS];
         end
         if (cy_we) carry_q <= cy_in;
         if (ov_we) ovf_q   <= ov_in;
      end
   end
endmodule

// File: rtl/cop_run_ctl.sv
module cop_run_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic go_set,
   input  logic stop,
   input  logic rom_set,
   input  logic rom_clr,
   output logic run_q,
   output logic romp_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         romp_q <= 1'b0;
      end else begin
         if (stop)        run_q <= 1'b0;
         else if (go_set) run_q <= 1'b1;
         if (rom_set)      romp_q <= 1'b1;
         else if (rom_clr) romp_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cop_prefix_flags.sv
module cop_prefix_flags
   import cop_flag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              stop,
   output mode_t             mode_q
);
   mode_t load_v, nxt;

   assign load_v = mode_t'(mode_in);

   always_comb begin
      nxt = mode_q;
      if (mode_we) nxt = load_v;
      if (stop) begin
         nxt.alt1 = 1'b0;
         nxt.alt2 = 1'b0;
         nxt.rpfx = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= '0;
      else        mode_q <= nxt;
   end
endmodule

// File: rtl/cop_irq_flag.sv
module cop_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop,
   input  logic irq_mask,
   input  logic host_rd,
   output logic irq_q
);
   logic raise, nxt;

   assign raise = stop & ~irq_mask;

   generate
      if (SET_WINS) begin : g_set_wins
         assign nxt = raise ? 1'b1 : (host_rd ? 1'b0 : irq_q);
      end else begin : g_clr_wins
         assign nxt = host_rd ? 1'b0 : (raise ? 1'b1 : irq_q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= nxt;
   end
endmodule

// File: rtl/cop_flag_reg.sv
module cop_flag_reg
   import cop_flag_pkg::*;
#(
   parameter int RES_W        = 16,
   parameter bit IRQ_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RES_W-1:0]  alu_res,
   input  logic              zs_we,
   input  logic              cy_we,
   input  logic              cy_in,
   input  logic              ov_we,
   input  logic              ov_in,
   input  logic              go_set,
   input  logic              stop,
   input  logic              rom_set,
   input  logic              rom_clr,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              host_rd,
   input  logic              irq_mask,
   output logic [STAT_W-1:0] status,
   output logic              irq
);
   generate
      if (RES_W < ZCHK_W) begin : g_bad_res_w
         $error("cop_flag_reg: RES_W must be at least 16");
      end
   endgenerate

   logic  zero_q, carry_q, sign_q, ovf_q;
   logic  run_q, romp_q, irq_q;
   mode_t mode_q;

   cop_cond_flags #(.RES_W(RES_W)) u_cond (
      .clk(clk), .rst_n(rst_n), .alu_res(alu_res),
      .zs_we(zs_we), .cy_we(cy_we), .cy_in(cy_in),
      .ov_we(ov_we), .ov_in(ov_in),
      .zero_q(zero_q), .carry_q(carry_q), .sign_q(sign_q), .ovf_q(ovf_q)
   );

   cop_run_ctl u_run (
      .clk(clk), .rst_n(rst_n), .go_set(go_set), .stop(stop),
      .rom_set(rom_set), .rom_clr(rom_clr),
      .run_q(run_q), .romp_q(romp_q)
   );

   cop_prefix_flags u_pfx (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
      .stop(stop), .mode_q(mode_q)
   );

   cop_irq_flag #(.SET_WINS(IRQ_SET_WINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .stop(stop), .irq_mask(irq_mask),
      .host_rd(host_rd), .irq_q(irq_q)
   );

   always_comb begin
      status          = '0;
      status[B_ZERO]  = zero_q;
      status[B_CARRY] = carry_q;
      status[B_SIGN]  = sign_q;
      status[B_OVF]   = ovf_q;
      status[B_RUN]   = run_q;
      status[B_ROMP]  = romp_q;
      status[B_ALT1]  = mode_q.alt1;
      status[B_ALT2]  = mode_q.alt2;
      status[B_IMML]  = mode_q.imml;
      status[B_IMMH]  = mode_q.immh;
      status[B_RPFX]  = mode_q.rpfx;
      status[B_IRQ]   = irq_q;
   end

   assign irq = irq_q;
endmodule

// File: rtl/cop_flag_reg_chk.sv
module cop_flag_reg_chk
   import cop_flag_pkg::*;
#(
   parameter int RES_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [RES_W-1:0]  alu_res,
   input logic              zs_we,
   input logic              cy_we,
   input logic              cy_in,
   input logic              ov_we,
   input logic              ov_in,
   input logic              go_set,
   input logic              stop,
   input logic              rom_set,
   input logic              rom_clr,
   input logic              mode_we,
   input logic [MODE_W-1:0] mode_in,
   input logic              host_rd,
   input logic              irq_mask,
   input logic [STAT_W-1:0] status,
   input logic              irq
);
   a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(zs_we)) |-> (status[B_ZERO] == ($past(alu_res[15:0]) == 16'h0)));

   a_r3_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(zs_we)) |-> (status[B_SIGN] == $past(alu_res[15])));

   a_r4_carry_load: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cy_we)) |-> (status[B_CARRY] == $past(cy_in)));

   a_r4_ovf_load: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ov_we)) |-> (status[B_OVF] == $past(ov_in)));

   a_r5_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(stop)) |-> !status[B_RUN]);

   a_r6_stop_clears_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(stop)) |-> (!status[B_ALT1] && !status[B_ALT2] && !status[B_RPFX]));

   a_r7_stop_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(stop && !irq_mask)) |-> status[B_IRQ]);

   a_r7_masked_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!status[B_IRQ]) && $past(!(stop && !irq_mask))) |-> !status[B_IRQ]);

   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(host_rd && !(stop && !irq_mask))) |-> !status[B_IRQ]);

   a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(irq)) |-> $past(stop && !irq_mask));

   a_r10_rom_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rom_set)) |-> status[B_ROMP]);

   a_r11_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!cy_we)) |-> $stable(status[B_CARRY]));
endmodule

bind cop_flag_reg cop_flag_reg_chk #(.RES_W(RES_W)) u_chk (.*);

// File: tb/cop_flag_reg_test.sv
`timescale 1ns/1ps
module cop_flag_reg_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] alu_res;
   logic        zs_we, cy_we, cy_in, ov_we, ov_in;
   logic        go_set, stop, rom_set, rom_clr, mode_we;
   logic [4:0]  mode_in;
   logic        host_rd, irq_mask;
   logic [15:0] status;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;
   logic [15:0] exp_st;

   always #4 clk = ~clk;

   cop_flag_reg uut (
      .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .zs_we(zs_we),
      .cy_we(cy_we), .cy_in(cy_in), .ov_we(ov_we), .ov_in(ov_in),
      .go_set(go_set), .stop(stop), .rom_set(rom_set), .rom_clr(rom_clr),
      .mode_we(mode_we), .mode_in(mode_in), .host_rd(host_rd),
      .irq_mask(irq_mask), .status(status), .irq(irq)
   );

   function automatic logic [15:0] model_next(input logic [15:0] s);
      logic [15:0] n;
      n = s;
      if (zs_we) begin
         n[1] = (alu_res == 16'h0);
         n[3] = alu_res[15];
      end
      if (cy_we) n[2] = cy_in;
      if (ov_we) n[4] = ov_in;
      if (stop)        n[5] = 1'b0;
      else if (go_set) n[5] = 1'b1;
      if (rom_set)      n[6] = 1'b1;
      else if (rom_clr) n[6] = 1'b0;
      if (mode_we) n[12:8] = {mode_in[4], mode_in[3], mode_in[2], mode_in[1], mode_in[0]};
      if (stop) begin
         n[8]  = 1'b0;
         n[9]  = 1'b0;
         n[12] = 1'b0;
      end
      if (stop && !irq_mask) n[15] = 1'b1;
      else if (host_rd)      n[15] = 1'b0;
      return n;
   endfunction

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R2 unused bits", status & 16'h6081, 16'h0000);
      chk("R3 zero/sign", status & 16'h000A, exp_st & 16'h000A);
      chk("R4 carry/overflow", status & 16'h0014, exp_st & 16'h0014);
      chk("R5 running", status & 16'h0020, exp_st & 16'h0020);
      chk("R10 rom pending", status & 16'h0040, exp_st & 16'h0040);
      chk("R6 prefix bits", status & 16'h1F00, exp_st & 16'h1F00);
      chk("R7/R8 irq bit", status & 16'h8000, exp_st & 16'h8000);
      chk("R9 irq pin", {15'h0, irq}, {15'h0, exp_st[15]});
   endtask

   task automatic idle();
      alu_res = 16'h0; zs_we = 0; cy_we = 0; cy_in = 0; ov_we = 0; ov_in = 0;
      go_set = 0; stop = 0; rom_set = 0; rom_clr = 0; mode_we = 0;
      mode_in = 5'h0; host_rd = 0; irq_mask = 0;
   endtask

   task automatic step();
      exp_st = model_next(exp_st);
      @(posedge clk);
      @(negedge clk);
      check_all();
   endtask

   task automatic rand_inputs(input int stop_pct);
      alu_res  = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
      zs_we    = 1'($urandom); cy_we = 1'($urandom); cy_in = 1'($urandom);
      ov_we    = 1'($urandom); ov_in = 1'($urandom);
      go_set   = ($urandom % 4 == 0); stop = (($urandom % 100) < stop_pct);
      rom_set  = ($urandom % 3 == 0); rom_clr = ($urandom % 3 == 0);
      mode_we  = 1'($urandom); mode_in = 5'($urandom);
      host_rd  = ($urandom % 4 == 0); irq_mask = ($urandom % 3 == 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      idle();
      rst_n = 0;
      exp_st = 16'h0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset status", status, 16'h0000);
      chk("R1 reset irq", {15'h0, irq}, 16'h0000);
      rst_n = 1;

      // R5 go set, R3 zero result, R4 loads
      go_set = 1; zs_we = 1; alu_res = 16'h0000; cy_we = 1; cy_in = 1; step();
      idle(); zs_we = 1; alu_res = 16'h8001; ov_we = 1; ov_in = 1; step();
      // R11: nothing strobed, all hold
      idle(); step();
      chk("R11 hold", status, 16'h0034 | 16'h0008);
      // R6 load prefix, then R7 unmasked stop clears alt1/alt2/rpfx and run
      mode_we = 1; mode_in = 5'h1F; step();
      idle(); stop = 1; step();
      chk("R7 irq raised", {15'h0, status[15]}, 16'h0001);
      // R8 host read clears
      idle(); host_rd = 1; step();
      chk("R8 read clears", {15'h0, status[15]}, 16'h0000);
      // R7 masked stop with no pending irq: stays clear
      idle(); stop = 1; irq_mask = 1; step();
      chk("R7 masked stop", {15'h0, irq}, 16'h0000);
      // R8 stop and read in same cycle: set wins
      idle(); stop = 1; host_rd = 1; step();
      chk("R8 set wins", {15'h0, irq}, 16'h0001);
      // R6 stop with mode_we: stop wins for alt1/alt2/rpfx, imm bits load
      idle(); stop = 1; irq_mask = 1; mode_we = 1; mode_in = 5'h1F; step();
      chk("R6 stop over mode", status & 16'h1F00, 16'h0C00);
      // R5 stop over go_set, R10 rom set over clr
      idle(); stop = 1; irq_mask = 1; go_set = 1; rom_set = 1; rom_clr = 1; step();
      chk("R5 stop wins", {15'h0, status[5]}, 16'h0000);
      chk("R10 set wins", {15'h0, status[6]}, 16'h0001);
      idle(); rom_clr = 1; step();

      for (int i = 0; i < 3000; i++) begin
         rand_inputs((i < 1500) ? 10 : 40);
         step();
      end

      // R1: reset in the middle of traffic
      rand_inputs(50);
      rst_n = 0;
      @(posedge clk); @(negedge clk);
      exp_st = 16'h0;
      chk("R1 mid reset status", status, 16'h0000);
      chk("R1 mid reset irq", {15'h0, irq}, 16'h0000);
      idle(); rst_n = 1;
      for (int i = 0; i < 500; i++) begin
         rand_inputs(20);
         step();
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule